// File: doc/BRIEF.md
# Microsecond Timer with Periodic Interrupts

This block keeps a 12-bit free-running count of microseconds. A one-cycle enable strobe, synchronous to the system clock and pulsed at a 1 MHz rate, moves the count up by one. The count rolls over from 4095 back to 0. Two interrupt requests are derived from fixed bits of the count. The fast request fires once every 128 counts and the slow request once every 1024 counts. Each request is a pulse one system clock wide.

Software reads the count over a simple byte-wide register bus. Address 0x24 returns the low eight bits. Address 0x25 returns the top four bits, and bits 7:4 of that register read as zero. A read of the low register also latches the upper four bits into a holding register, and the next read of the high register returns that latched value. A low-then-high pair of reads therefore gives a consistent 12-bit value, even if the count carries between the two reads. The block has no writable state, and any write on the bus is ignored.

Top module: `usec_timer`

## Requirements
- R1: After synchronous reset, the count, the holding register, the read data and both interrupt outputs are zero.
- R2: The count rises by exactly one on each clock where `tick_1us` is high, and it holds its value on every other clock.
- R3: When the count is 4095, a tick takes it to 0.
- R4: `irq_128us` is high for exactly one clock, in the cycle after a tick that makes bits 6:0 of the count all zero. This gives one pulse per 128 ticks.
- R5: `irq_1024us` is high for exactly one clock, in the cycle after a tick that makes bits 9:0 of the count all zero. This includes the wrap to 0.
- R6: A read (`bus_sel`=1, `bus_we`=0) of address 0x24 places bits 7:0 of the count on `bus_rdata` in the next cycle.
- R7: A read of 0x24 copies bits 11:8 of the count into the holding register. A read of 0x25 returns the holding register in bits 3:0 of `bus_rdata` in the next cycle, with bits 7:4 zero. A carry between the two reads does not change the value returned.
- R8: A read of 0x25 does not change the holding register. Repeated high reads, or a high read with no low read since reset, return the last latched value (zero after reset).
- R9: A write cycle (`bus_sel`=1, `bus_we`=1) to any address changes neither the count nor the holding register, and `bus_rdata` is zero in the next cycle.
- R10: A read of any address other than 0x24 or 0x25, or a cycle with `bus_sel` low, gives zero on `bus_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle 1 MHz advance strobe |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | Access is a write (ignored) when high |
| bus_addr | input | 8 | Register address |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| irq_128us | output | 1 | One-clock pulse every 128 counts |
| irq_1024us | output | 1 | One-clock pulse every 1024 counts |

## Verification
The hardest case to reach is a carry into the upper four bits that lands between the two halves of a read. Left alone, that carry happens only once every 256 ticks, and it must fall exactly between the low read and the high read. The stimulus first drives the count to 0x0FF and reads the low register. It then issues a single tick and reads the high register, which must still return the old nibble. A second low/high pair then shows the new nibble.

The slow interrupt at the wrap from 4095 to 0 is reached by ticking through the whole range. The pulses are counted over each segment of ticks.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

    localparam int CNT_W     = 12;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int TAP_FAST  = 6;
    localparam int TAP_SLOW  = 9;
    localparam logic [ADDR_W-1:0] LO_ADDR = 8'h24;
    localparam logic [ADDR_W-1:0] HI_ADDR = 8'h25;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_LO   = 2'd1,
        RSEL_HI   = 2'd2
    } rsel_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } bus_req_t;

    function automatic rsel_e decode_read(bus_req_t req,
                                          logic [ADDR_W-1:0] lo,
                                          logic [ADDR_W-1:0] hi);
        rsel_e r;
        r = RSEL_NONE;
        if (req.sel && !req.we) begin
            if (req.addr == lo)      r = RSEL_LO;
            else if (req.addr == hi) r = RSEL_HI;
        end
        return r;
    endfunction

endpackage

// File: rtl/utmr_counter.sv
module utmr_counter #(
    parameter int W = utmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= count + W'(1);
    end

endmodule

// File: rtl/utmr_fall_det.sv
module utmr_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);

    logic level_d;

    always_ff @(posedge clk) begin
        if (rst) level_d <= 1'b0;
        else     level_d <= level;
    end

    // A falling tap bit closes one full period of that bit.
    assign pulse = level_d & ~level;

endmodule

// File: rtl/utmr_readport.sv
module utmr_readport
    import utmr_pkg::*;
#(
    parameter int                CW   = CNT_W,
    parameter int                DW   = DATA_W,
    parameter logic [ADDR_W-1:0] A_LO = LO_ADDR,
    parameter logic [ADDR_W-1:0] A_HI = HI_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic [CW-1:0] count,
    output logic [DW-1:0] rdata
);

    localparam int HW = CW - DW;

    rsel_e          rsel;
    logic [HW-1:0]  hold_q;

    assign rsel = decode_read(req, A_LO, A_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            rdata  <= '0;
        end else begin
            unique case (rsel)
                RSEL_LO: begin
                    rdata  <= count[DW-1:0];
                    hold_q <= count[CW-1:DW];
                end
                RSEL_HI: rdata <= DW'(hold_q);
                default: rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import utmr_pkg::*;
#(
    parameter int                CW    = CNT_W,
    parameter int                DW    = DATA_W,
    parameter int                T_FST = TAP_FAST,
    parameter int                T_SLW = TAP_SLOW,
    parameter logic [ADDR_W-1:0] A_LO  = LO_ADDR,
    parameter logic [ADDR_W-1:0] A_HI  = HI_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1us,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_128us,
    output logic              irq_1024us
);

    localparam int N_TAPS = 2;

    logic [CW-1:0]     count_q;
    logic [N_TAPS-1:0] tap_lvl;
    logic [N_TAPS-1:0] tap_irq;
    bus_req_t          req;

    assign req = '{sel: bus_sel, we: bus_we, addr: bus_addr};
    assign tap_lvl = {count_q[T_SLW], count_q[T_FST]};

    utmr_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_1us),
        .count (count_q)
    );

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        utmr_fall_det u_fd (
            .clk   (clk),
            .rst   (rst),
            .level (tap_lvl[i]),
            .pulse (tap_irq[i])
        );
    end

    assign irq_128us  = tap_irq[0];
    assign irq_1024us = tap_irq[1];

    utmr_readport #(.CW(CW), .DW(DW), .A_LO(A_LO), .A_HI(A_HI)) u_rp (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .count (count_q),
        .rdata (bus_rdata)
    );

endmodule

// File: rtl/utmr_checker.sv
module utmr_checker #(
    parameter int           CW    = 12,
    parameter int           DW    = 8,
    parameter int           AW    = 8,
    parameter int           T_FST = 6,
    parameter int           T_SLW = 9,
    parameter logic [AW-1:0] A_HI = 8'h25
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          sel,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] rdata,
    input logic          irq_f,
    input logic          irq_s,
    input logic [CW-1:0] count
);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == CW'($past(count) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '1) |=> count == '0);

    p_fast_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq_f |=> !irq_f);

    p_fast_aligned_r4: assert property (@(posedge clk) disable iff (rst)
        irq_f |-> count[T_FST:0] == '0);

    p_slow_single_r5: assert property (@(posedge clk) disable iff (rst)
        irq_s |=> !irq_s);

    p_slow_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        irq_s |-> count[T_SLW:0] == '0);

    p_hi_reserved_r7: assert property (@(posedge clk) disable iff (rst)
        (sel && !we && addr == A_HI) |=> rdata[DW-1:CW-DW] == '0);

    p_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (sel && we) |=> rdata == '0);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !sel |=> rdata == '0);

endmodule

bind usec_timer utmr_checker #(
    .CW(CW), .DW(DW), .AW(utmr_pkg::ADDR_W),
    .T_FST(T_FST), .T_SLW(T_SLW), .A_HI(A_HI)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_1us),
    .sel   (bus_sel),
    .we    (bus_we),
    .addr  (bus_addr),
    .rdata (bus_rdata),
    .irq_f (irq_128us),
    .irq_s (irq_1024us),
    .count (count_q)
);

// File: tb/usec_timer_tb.sv
module usec_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       sel = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] rdata;
    logic       irq_f, irq_s;

    int checks = 0;
    int errors = 0;
    int n_fast = 0;
    int n_slow = 0;
    bit fast_d = 0, slow_d = 0, wide_seen = 0, done = 0;

    always #2.5 clk = ~clk;

    usec_timer u_dut (
        .clk(clk), .rst(rst), .tick_1us(tick),
        .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_rdata(rdata), .irq_128us(irq_f), .irq_1024us(irq_s)
    );

    // fields: ticks[47:32], low[31:24], high[23:16], fast pulses[15:8], slow pulses[7:0]
    localparam logic [47:0] VEC [6] = '{
        {16'd1,    8'h01, 8'h00, 8'd0,  8'd0},
        {16'd126,  8'h7F, 8'h00, 8'd0,  8'd0},
        {16'd1,    8'h80, 8'h00, 8'd1,  8'd0},
        {16'd896,  8'h00, 8'h04, 8'd7,  8'd1},
        {16'd3071, 8'hFF, 8'h0F, 8'd23, 8'd2},
        {16'd1,    8'h00, 8'h00, 8'd1,  8'd1}
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_f) n_fast++;
            if (irq_s) n_slow++;
            if ((irq_f && fast_d) || (irq_s && slow_d)) wide_seen = 1;
            fast_d = irq_f;
            slow_d = irq_s;
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk) begin sel = 1'b1; we = 1'b0; addr = a; end
        @(negedge clk) begin sel = 1'b0; d = rdata; end
    endtask

    task automatic wr(logic [7:0] a);
        @(negedge clk) begin sel = 1'b1; we = 1'b1; addr = a; end
        @(negedge clk) begin sel = 1'b0; we = 1'b0; end
        chk("R9 write rdata", int'(rdata), 0);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        do_reset();
        chk("R1 rdata after reset", int'(rdata), 0);
        chk("R1 irq_128us after reset", int'(irq_f), 0);
        chk("R1 irq_1024us after reset", int'(irq_s), 0);
        rd(8'h25, d); chk("R1 high hold after reset", int'(d), 0);
        rd(8'h24, d); chk("R1 low after reset", int'(d), 0);

        // table walk: R2 R3 R4 R5 R6 R7
        foreach (VEC[k]) begin
            n_fast = 0; n_slow = 0;
            do_ticks(int'(VEC[k][47:32]));
            chk("R4 fast pulse count", n_fast, int'(VEC[k][15:8]));
            chk("R5 slow pulse count", n_slow, int'(VEC[k][7:0]));
            rd(8'h24, d); chk("R6 low byte", int'(d), int'(VEC[k][31:24]));
            rd(8'h25, d); chk("R7 high nibble", int'(d), int'(VEC[k][23:16]));
        end
        chk("R4 R5 pulse width one clock", int'(wide_seen), 0);

        // R7 carry between the two halves of a read
        do_ticks(255);
        rd(8'h24, d); chk("R7 low before carry", int'(d), 8'hFF);
        do_ticks(1);
        rd(8'h25, d); chk("R7 high keeps snapshot", int'(d), 8'h00);
        rd(8'h24, d); chk("R7 low after carry", int'(d), 8'h00);
        rd(8'h25, d); chk("R7 high after new snapshot", int'(d), 8'h01);

        // R2 no strobe, no advance
        repeat (40) @(negedge clk);
        rd(8'h24, d); chk("R2 hold without tick", int'(d), 8'h00);

        // R9 writes ignored
        wr(8'h24);
        wr(8'h25);
        rd(8'h25, d); chk("R9 hold unchanged by write", int'(d), 8'h01);
        rd(8'h24, d); chk("R9 count unchanged by write", int'(d), 8'h00);

        // R10 other addresses
        rd(8'h26, d); chk("R10 addr 0x26", int'(d), 0);
        rd(8'h23, d); chk("R10 addr 0x23", int'(d), 0);
        rd(8'hA4, d); chk("R10 addr 0xA4", int'(d), 0);
        @(negedge clk); chk("R10 idle rdata", int'(rdata), 0);

        // R8 high reads do not relatch
        do_reset();
        rd(8'h25, d); chk("R8 high with no low read", int'(d), 0);
        do_ticks(16'h305);
        rd(8'h24, d); chk("R6 low at 0x305", int'(d), 8'h05);
        do_ticks(16'h100);
        rd(8'h25, d); chk("R8 first high read", int'(d), 8'h03);
        rd(8'h25, d); chk("R8 repeated high read", int'(d), 8'h03);
        rd(8'h24, d); chk("R6 low at 0x405", int'(d), 8'h05);
        rd(8'h25, d); chk("R7 high at 0x405", int'(d), 8'h04);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule